// File: doc/BRIEF.md
# Parallel Flash Program/Erase Sequencer

This block sits on the host side of a byte-wide parallel flash and turns a single request into the full bus conversation that the flash needs. A request asks for one of three operations: program one byte, erase one sector, or erase the whole array. The sequencer first writes the unlock command bytes. It then waits for the flash's internal operation to finish, reads the target location once more to verify the result, and reports the outcome.

Completion is found in one of two ways, chosen for each request. In polled mode the block keeps reading the target address and watches bit 6, which the flash flips on every read while it is busy. Two reads that agree are not enough, because the operation can finish between polls. Two further reads must agree before the result is accepted. In fixed-wait mode no polling takes place: the block waits a parameterised worst-case number of cycles for the operation type. A per-operation timeout limits polling.

Requests use a valid/ready handshake. `req_ready` is high only when the block is idle, and a request is taken on a cycle where valid and ready are both high. A requester that holds valid while ready is low is simply stalled, and its payload is not sampled. The flash-side bus is a simple synchronous strobe bus. Read data returns on the cycle after the read strobe.

Top module: `flash_prog_seq`

## Requirements
- R1: A program request (`req_op`=0) produces exactly four bus writes, as (address,data) pairs: (5555h,AAh), (2AAAh,55h), (5555h,A0h), then (req_addr,req_data).
- R2: A sector erase (`req_op`=1) produces six writes: (5555h,AAh), (2AAAh,55h), (5555h,80h), (5555h,AAh), (2AAAh,55h), then (req_addr,30h).
- R3: A chip erase (`req_op`=2) produces the same first five writes as R2, and its sixth write is (5555h,10h).
- R4: Every bus strobe lasts one cycle and is followed by at least one cycle with neither strobe. Write and read strobes are never high together.
- R5: In polled mode, completion is accepted only after four consecutive reads of the target address return the same bit 6. This is one matching pair plus two confirming reads. Any mismatch restarts the count.
- R6: In fixed-wait mode (`req_fixed_wait`=1) there are no polling reads. The single verify read comes at least the operation's wait limit in cycles after the final command write.
- R7: If polling has not completed within the operation's timeout limit, `done` and `err_timeout` pulse together, no verify read is issued, and `err_verify` stays low.
- R8: After completion, the target address is read once. A program expects `req_data` and an erase expects FFh. A difference raises `err_verify` together with `done`.
- R9: `req_ready` is high only while idle. A request is accepted on a cycle with valid and ready both high. While an operation runs, a valid request is neither accepted nor sampled. `req_op`=3 acts as a chip erase.
- R10: After reset the block is idle with `req_ready` high and no strobes. `done`, `err_timeout` and `err_verify` are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_op | input | 2 | 0 program, 1 sector erase, 2 or 3 chip erase |
| req_addr | input | AW | Target byte or sector address |
| req_data | input | 8 | Byte to program |
| req_fixed_wait | input | 1 | 1 selects fixed worst-case wait instead of polling |
| bus_wr | output | 1 | Flash write strobe |
| bus_rd | output | 1 | Flash read strobe |
| bus_addr | output | AW | Flash address |
| bus_wdata | output | 8 | Flash write data |
| bus_rdata | input | 8 | Flash read data, valid the cycle after `bus_rd` |
| done | output | 1 | Operation finished (pulse) |
| err_timeout | output | 1 | Polling timed out (pulse with done) |
| err_verify | output | 1 | Read-back mismatch (pulse with done) |

## Verification
The hardest case is a single false match inside the busy window. The flash model repeats its toggle bit once during the busy period, so two consecutive reads agree while the operation is still running. The glitch is armed from the bench for the third busy read of one program. A sequencer that accepted after a single pair would verify too early and see the complemented bit 7. The bench therefore checks that no verify error occurs and that at least four reads land after the model has finished. A separately held-stuck model and a corrupting model drive the timeout and verify-error paths.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_CHIP = 2'd2
  } fop_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR,
    ST_WGAP,
    ST_WAIT,
    ST_PRD,
    ST_PCAP,
    ST_VRD,
    ST_VCAP
  } fst_e;

  localparam logic [7:0] ERASED_BYTE = 8'hFF;
  localparam int unsigned TOGGLE_BIT = 6;
endpackage

// File: rtl/flash_seq_cmd.sv
module flash_seq_cmd
  import flash_seq_pkg::*;
#(
  parameter int AW     = 19,
  parameter int UNLK_A = 'h5555,
  parameter int UNLK_B = 'h2AAA
) (
  input  fop_e          op,
  input  logic [2:0]    step,
  input  logic [AW-1:0] tgt_addr,
  input  logic [7:0]    tgt_data,
  output logic [AW-1:0] cmd_addr,
  output logic [7:0]    cmd_data,
  output logic          cmd_last
);
  localparam logic [AW-1:0] ADR_A = AW'(UNLK_A);
  localparam logic [AW-1:0] ADR_B = AW'(UNLK_B);

  logic is_prog;
  assign is_prog  = (op == OP_PROG);
  assign cmd_last = is_prog ? (step == 3'd3) : (step == 3'd5);

  always_comb begin
    cmd_addr = ADR_A;
    cmd_data = 8'hAA;
    case (step)
      3'd0: begin cmd_addr = ADR_A; cmd_data = 8'hAA; end
      3'd1: begin cmd_addr = ADR_B; cmd_data = 8'h55; end
      3'd2: begin cmd_addr = ADR_A; cmd_data = is_prog ? 8'hA0 : 8'h80; end
      3'd3: begin
        cmd_addr = is_prog ? tgt_addr : ADR_A;
        cmd_data = is_prog ? tgt_data : 8'hAA;
      end
      3'd4: begin cmd_addr = ADR_B; cmd_data = 8'h55; end
      3'd5: begin
        cmd_addr = (op == OP_SECT) ? tgt_addr : ADR_A;
        cmd_data = (op == OP_SECT) ? 8'h30 : 8'h10;
      end
      default: begin cmd_addr = ADR_A; cmd_data = 8'hAA; end
    endcase
  end
endmodule

// File: rtl/flash_seq_timer.sv
module flash_seq_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] limit,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= limit;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // R7
  load_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && limit != '0) |=> !expired);
endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import flash_seq_pkg::*;
#(
  parameter int AW        = 19,
  parameter int UNLK_A    = 'h5555,
  parameter int UNLK_B    = 'h2AAA,
  parameter int CONFIRM   = 2,
  parameter int TMO_PROG  = 1500,
  parameter int TMO_SECT  = 1_500_000,
  parameter int TMO_CHIP  = 6_000_000,
  parameter int WAIT_PROG = 1000,
  parameter int WAIT_SECT = 1_250_000,
  parameter int WAIT_CHIP = 5_000_000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_data,
  input  logic          req_fixed_wait,
  output logic          bus_wr,
  output logic          bus_rd,
  output logic [AW-1:0] bus_addr,
  output logic [7:0]    bus_wdata,
  input  logic [7:0]    bus_rdata,
  output logic          done,
  output logic          err_timeout,
  output logic          err_verify
);
  localparam int MATCH_NEED = CONFIRM + 1;
  localparam int MC_W  = $clog2(MATCH_NEED + 1);
  localparam int MAX_T = (TMO_PROG > TMO_SECT) ? ((TMO_PROG > TMO_CHIP) ? TMO_PROG : TMO_CHIP)
                                               : ((TMO_SECT > TMO_CHIP) ? TMO_SECT : TMO_CHIP);
  localparam int MAX_W = (WAIT_PROG > WAIT_SECT) ? ((WAIT_PROG > WAIT_CHIP) ? WAIT_PROG : WAIT_CHIP)
                                                 : ((WAIT_SECT > WAIT_CHIP) ? WAIT_SECT : WAIT_CHIP);
  localparam int MAX_L = (MAX_T > MAX_W) ? MAX_T : MAX_W;
  localparam int TW    = $clog2(MAX_L + 1);

  fst_e          st;
  fop_e          op_q, op_in;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;
  logic          fixed_q;
  logic [2:0]    step;
  logic          prev_tog, have_prev;
  logic [MC_W-1:0] mcnt;
  logic          done_q, tmo_q, verr_q;
  logic [AW-1:0] cmd_addr;
  logic [7:0]    cmd_data;
  logic          cmd_last;
  logic          tmr_load, tmr_exp;
  logic [TW-1:0] tmr_limit;
  logic [7:0]    expect_byte;
  logic          tog_now;

  always_comb begin
    case (req_op)
      2'd0:    op_in = OP_PROG;
      2'd1:    op_in = OP_SECT;
      default: op_in = OP_CHIP;
    endcase
  end

  always_comb begin
    case (op_q)
      OP_PROG: tmr_limit = fixed_q ? TW'(WAIT_PROG) : TW'(TMO_PROG);
      OP_SECT: tmr_limit = fixed_q ? TW'(WAIT_SECT) : TW'(TMO_SECT);
      default: tmr_limit = fixed_q ? TW'(WAIT_CHIP) : TW'(TMO_CHIP);
    endcase
  end

  flash_seq_cmd #(.AW(AW), .UNLK_A(UNLK_A), .UNLK_B(UNLK_B)) u_cmd (
    .op(op_q), .step(step), .tgt_addr(addr_q), .tgt_data(data_q),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_last(cmd_last)
  );

  assign tmr_load = (st == ST_WGAP) && cmd_last;

  flash_seq_timer #(.W(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .limit(tmr_limit), .expired(tmr_exp)
  );

  assign req_ready   = (st == ST_IDLE);
  assign bus_wr      = (st == ST_WR);
  assign bus_rd      = ((st == ST_PRD) && !tmr_exp) || (st == ST_VRD);
  assign bus_addr    = (st == ST_WR) ? cmd_addr : addr_q;
  assign bus_wdata   = (st == ST_WR) ? cmd_data : 8'h00;
  assign expect_byte = (op_q == OP_PROG) ? data_q : ERASED_BYTE;
  assign tog_now     = bus_rdata[TOGGLE_BIT];
  assign done        = done_q;
  assign err_timeout = tmo_q;
  assign err_verify  = verr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE; op_q <= OP_PROG; addr_q <= '0; data_q <= '0; fixed_q <= 1'b0;
      step <= '0; prev_tog <= 1'b0; have_prev <= 1'b0; mcnt <= '0;
      done_q <= 1'b0; tmo_q <= 1'b0; verr_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      tmo_q  <= 1'b0;
      verr_q <= 1'b0;
      case (st)
        ST_IDLE: if (req_valid) begin
          op_q <= op_in; addr_q <= req_addr; data_q <= req_data;
          fixed_q <= req_fixed_wait; step <= '0; st <= ST_WR;
        end
        ST_WR: st <= ST_WGAP;
        ST_WGAP: begin
          if (cmd_last) begin
            have_prev <= 1'b0;
            mcnt      <= '0;
            st        <= fixed_q ? ST_WAIT : ST_PRD;
          end else begin
            step <= step + 3'd1;
            st   <= ST_WR;
          end
        end
        ST_WAIT: if (tmr_exp) st <= ST_VRD;
        ST_PRD: begin
          if (tmr_exp) begin
            done_q <= 1'b1; tmo_q <= 1'b1; st <= ST_IDLE;
          end else begin
            st <= ST_PCAP;
          end
        end
        ST_PCAP: begin
          have_prev <= 1'b1;
          prev_tog  <= tog_now;
          if (have_prev && (tog_now == prev_tog)) begin
            if (mcnt == MC_W'(MATCH_NEED - 1)) st <= ST_VRD;
            else begin mcnt <= mcnt + 1'b1; st <= ST_PRD; end
          end else begin
            mcnt <= '0;
            st   <= ST_PRD;
          end
        end
        ST_VRD: st <= ST_VCAP;
        ST_VCAP: begin
          done_q <= 1'b1;
          verr_q <= (bus_rdata != expect_byte);
          st     <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R4
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_rd));
  // R4
  strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr || bus_rd) |=> !(bus_wr || bus_rd));
  // R9
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7
  tmo_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_timeout |-> (done && !err_verify));
  // R7
  tmo_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_timeout |-> !$past(bus_rd));
  // R8
  verr_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_verify |-> done);
endmodule

// File: tb/tb_flash_prog_seq.sv
module tb_flash_prog_seq;
  localparam int AW = 16;
  localparam int TP = 200, TS = 400, TC = 600;
  localparam int WP = 60, WS = 120, WC = 160;
  localparam int BUSY_P = 20, BUSY_S = 50, BUSY_C = 80;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n, req_valid, req_ready, req_fixed_wait;
  logic [1:0]    req_op;
  logic [AW-1:0] req_addr, bus_addr;
  logic [7:0]    req_data, bus_wdata, bus_rdata;
  logic          bus_wr, bus_rd, done, err_timeout, err_verify;

  flash_prog_seq #(.AW(AW), .TMO_PROG(TP), .TMO_SECT(TS), .TMO_CHIP(TC),
                   .WAIT_PROG(WP), .WAIT_SECT(WS), .WAIT_CHIP(WC)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
    .req_fixed_wait(req_fixed_wait), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .done(done), .err_timeout(err_timeout), .err_verify(err_verify)
  );

  int checks = 0, fails = 0;
  task automatic check(bit ok, string rq, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // ---------------- behavioural flash model ----------------
  logic [7:0] mem [256];
  int busy_cnt = 0, busy_rd = 0, mst = 0;
  bit stuck = 0, glitch_arm = 0, corrupt = 0, tog = 0;
  int pkind = 0;
  logic [AW-1:0] paddr;
  logic [7:0] pdata;

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'hA5;
    bus_rdata = 8'h00;
  end

  task automatic apply_pending();
    case (pkind)
      0: mem[paddr[7:0]] = pdata ^ {7'b0, corrupt};
      1: for (int i = 0; i < 16; i++) mem[{paddr[7:4], 4'(i)}] = 8'hFF;
      default: for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
    endcase
  endtask

  task automatic start_busy(int kind, int cycles, logic [AW-1:0] a, logic [7:0] d);
    pkind = kind; paddr = a; pdata = d; busy_cnt = cycles; busy_rd = 0;
  endtask

  always @(posedge clk) begin
    if (busy_cnt > 0 && !stuck) begin
      busy_cnt = busy_cnt - 1;
      if (busy_cnt == 0) apply_pending();
    end
    if (bus_rd) begin
      if (busy_cnt > 0) begin
        busy_rd++;
        if (glitch_arm && busy_rd == 3) glitch_arm = 0;
        else tog = ~tog;
        bus_rdata <= {~pdata[7], tog, 6'h15};
      end else begin
        bus_rdata <= mem[bus_addr[7:0]];
      end
    end
    if (bus_wr && busy_cnt == 0) begin
      case (mst)
        0: mst = (bus_addr == 16'h5555 && bus_wdata == 8'hAA) ? 1 : 0;
        1: mst = (bus_addr == 16'h2AAA && bus_wdata == 8'h55) ? 2 : 0;
        2: mst = (bus_addr == 16'h5555 && bus_wdata == 8'hA0) ? 3 :
                 (bus_addr == 16'h5555 && bus_wdata == 8'h80) ? 4 : 0;
        3: begin start_busy(0, BUSY_P, bus_addr, bus_wdata); mst = 0; end
        4: mst = (bus_addr == 16'h5555 && bus_wdata == 8'hAA) ? 5 : 0;
        5: mst = (bus_addr == 16'h2AAA && bus_wdata == 8'h55) ? 6 : 0;
        6: begin
          if (bus_wdata == 8'h30) start_busy(1, BUSY_S, bus_addr, 8'hFF);
          else if (bus_wdata == 8'h10 && bus_addr == 16'h5555) start_busy(2, BUSY_C, bus_addr, 8'hFF);
          mst = 0;
        end
        default: mst = 0;
      endcase
    end
  end

  // ---------------- scoreboard ----------------
  logic [AW+7:0] exp_q [$];
  string cur_tag = "R1";
  int cyc = 0, rd_cnt = 0, post_rd = 0, first_rd_cyc = -1, last_wr_cyc = 0, gap_viol = 0;
  bit prev_strobe = 0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if ((bus_wr || bus_rd) && prev_strobe) gap_viol++;
      if (bus_wr && bus_rd) gap_viol++;
      prev_strobe = bus_wr || bus_rd;
      if (bus_wr) begin
        last_wr_cyc = cyc;
        if (exp_q.size() == 0) check(0, cur_tag, "unexpected write", bus_addr, 0);
        else begin
          logic [AW+7:0] e;
          e = exp_q.pop_front();
          check({bus_addr, bus_wdata} == e, cur_tag, "write addr/data", {bus_addr, bus_wdata}, e);
        end
      end
      if (bus_rd) begin
        rd_cnt++;
        if (first_rd_cyc < 0) first_rd_cyc = cyc;
        if (busy_cnt <= 1 && !stuck) post_rd++;
      end
    end
  end

  task automatic push_w(logic [AW-1:0] a, logic [7:0] d);
    exp_q.push_back({a, d});
  endtask

  int done_cyc = 0;

  task automatic run_op(logic [1:0] op, logic [AW-1:0] a, logic [7:0] d, bit fx,
                        bit e_tmo, bit e_verr, bit poke, string tag);
    int n;
    push_w(16'h5555, 8'hAA); push_w(16'h2AAA, 8'h55);
    if (op == 2'd0) begin
      push_w(16'h5555, 8'hA0); push_w(a, d);
    end else begin
      push_w(16'h5555, 8'h80); push_w(16'h5555, 8'hAA); push_w(16'h2AAA, 8'h55);
      if (op == 2'd1) push_w(a, 8'h30); else push_w(16'h5555, 8'h10);
    end
    cur_tag = tag; rd_cnt = 0; post_rd = 0; first_rd_cyc = -1;
    @(negedge clk);
    req_op = op; req_addr = a; req_data = d; req_fixed_wait = fx; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    // R9 ready drops once the request is taken
    check(req_ready == 1'b0, "R9", "ready after accept", req_ready, 0);
    n = 0;
    while (!done && n < 5000) begin
      if (poke && n < 10) begin
        req_valid = 1'b1; req_op = 2'd1; req_addr = 16'h0BEE;
        @(negedge clk);
        // R9 busy sequencer refuses a new request
        check(req_ready == 1'b0, "R9", "ready while busy", req_ready, 0);
      end else begin
        req_valid = 1'b0;
        @(negedge clk);
      end
      n++;
    end
    req_valid = 1'b0;
    done_cyc = cyc;
    check(done == 1'b1, tag, "done seen", done, 1);
    // R7 / R8 outcome flags
    check(err_timeout == e_tmo, "R7", "err_timeout", err_timeout, e_tmo);
    check(err_verify == e_verr, "R8", "err_verify", err_verify, e_verr);
    check(exp_q.size() == 0, tag, "writes outstanding", exp_q.size(), 0);
    exp_q.delete();
    @(negedge clk);
    // R10 single-cycle pulse
    check(done == 1'b0 && err_timeout == 1'b0 && err_verify == 1'b0, "R10", "pulse width",
          {done, err_timeout, err_verify}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R10 watchdog expired: actual 0 expected 1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_addr = '0; req_data = '0; req_fixed_wait = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(req_ready == 1'b1 && done == 1'b0, "R10", "reset ready/done", {req_ready, done}, 2);
    check(bus_wr == 1'b0 && bus_rd == 1'b0, "R4", "reset strobes", {bus_wr, bus_rd}, 0);

    // R1 polled program
    run_op(2'd0, 16'h0012, 8'h3C, 0, 0, 0, 0, "R1");
    check(rd_cnt >= 5, "R5", "poll plus verify reads", rd_cnt, 5);

    // R5 false match during busy must not end polling
    glitch_arm = 1;
    run_op(2'd0, 16'h0020, 8'h5A, 0, 0, 0, 0, "R5");
    check(post_rd >= 4, "R5", "reads after flash finished", post_rd, 4);

    // R2 sector erase
    run_op(2'd1, 16'h1230, 8'h00, 0, 0, 0, 0, "R2");

    // R6 fixed-wait program
    run_op(2'd0, 16'h0040, 8'h81, 1, 0, 0, 0, "R6");
    check(rd_cnt == 1, "R6", "read count in fixed mode", rd_cnt, 1);
    check(first_rd_cyc - last_wr_cyc >= WP, "R6", "wait before verify", first_rd_cyc - last_wr_cyc, WP);

    // R3 chip erase polled
    run_op(2'd2, 16'h0044, 8'h00, 0, 0, 0, 0, "R3");

    // R7 stuck flash times out
    stuck = 1;
    run_op(2'd0, 16'h0050, 8'h11, 0, 1, 0, 0, "R7");
    check(done_cyc - last_wr_cyc >= TP, "R7", "timeout delay", done_cyc - last_wr_cyc, TP);
    stuck = 0;
    repeat (2 * BUSY_P) @(negedge clk);

    // R8 corrupted program detected
    corrupt = 1;
    run_op(2'd0, 16'h0060, 8'h0F, 0, 0, 1, 0, "R8");
    corrupt = 0;

    // R9 op code 3 acts as chip erase, fixed wait
    run_op(2'd3, 16'h0070, 8'h00, 1, 0, 0, 0, "R9");
    check(rd_cnt == 1, "R6", "read count fixed chip erase", rd_cnt, 1);

    // R9 request held while busy is ignored
    run_op(2'd0, 16'h0080, 8'h77, 0, 0, 0, 1, "R9");
    repeat (20) @(negedge clk);
    check(exp_q.size() == 0 && !bus_wr, "R9", "no extra op started", exp_q.size(), 0);

    // R4 strobe spacing over the whole run
    check(gap_viol == 0, "R4", "strobe gap violations", gap_viol, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule